// File: doc/BRIEF.md
# Multi-Sweep Range Cell Integrator

This block adds up radar echo amplitudes for each range cell over the most recent M sweeps. It takes a stream of samples, one per clock at most. Each sample carries an echo amplitude, the index of its range cell, and a flag that marks the first sample of a new sweep. For every sample the block returns the updated window total for that range cell.

The total is kept recursively. A per-cell sum memory holds the current total. A circular history memory of M×R echoes holds the values that must leave the window. When a sample arrives, the history entry for its cell and the current sweep slot is read as the departing echo, and the new echo is written over it. The new total is the stored total plus the new echo minus the departing echo.

A system with two received channels places two copies side by side, one per channel. Each sweep must present every range cell exactly once. The cells may arrive in any order, and idle cycles may fall between samples.

Top module: `sweep_integrator`

## Requirements
- R1: While reset is asserted and right after it, out_valid is low, every cell total is zero and the history counts as empty.
- R2: out_valid goes high exactly two clock cycles after a cycle with in_valid high, with out_range equal to that sample's in_range. It is low two cycles after any cycle with in_valid low.
- R3: Once the window is full, out_sum equals the cell's previous total plus the new echo minus the echo the same cell received M sweeps earlier.
- R4: During the first M sweeps after reset, the departing echo is taken as zero, so out_sum is the plain total of that cell's echoes since reset.
- R5: Cells are independent: an echo for one range index never changes the total of another.
- R6: A sweep begins on a sample with in_valid and in_first both high. The first such sample after reset opens sweep 0. in_first with in_valid low is ignored.
- R7: out_sum is ECHO_W + ceil(log2 M) bits wide. M echoes at full scale (2^ECHO_W − 1) give M·(2^ECHO_W − 1) with no wrap.
- R8: Within a sweep the range indices may arrive in any order, as long as each appears exactly once.
- R9: Idle cycles (in_valid low) between samples leave every total and the sweep position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_first | input | 1 | Sample is the first of a new sweep |
| in_range | input | clog2(RANGES) | Range cell index of the sample |
| in_echo | input | ECHO_W | Echo amplitude, unsigned |
| out_valid | output | 1 | Result present |
| out_range | output | clog2(RANGES) | Range cell index of the result |
| out_sum | output | ECHO_W+clog2(SWEEPS) | Window total for the cell |

## Verification
Ten sweeps with linear echo ramps of differing slope and offset run past the window depth twice. The first M sweeps show that nothing is subtracted while the window fills, and the later sweeps show that the echo from exactly M sweeps back is the one removed. Reversed visiting order separates cell addressing from arrival order. Sweeps with stray start flags on idle cycles show whether the sweep pointer advances only on real samples. A single-cell burst among zero cells shows leakage between cells, and repeated full-scale sweeps after a mid-run reset test the sum width and the cleared state.

// File: rtl/sweep_integ_pkg.sv
package sweep_integ_pkg;
  localparam int unsigned DEF_ECHO_W = 8;
  localparam int unsigned DEF_SWEEPS = 4;
  localparam int unsigned DEF_RANGES = 16;

  // Width that holds the total of m echoes of ew bits without wrap.
  function automatic int unsigned total_width(int unsigned ew, int unsigned m);
    return ew + $clog2(m);
  endfunction

  function automatic int unsigned index_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sweep_tracker.sv
module sweep_tracker #(
  parameter int unsigned SWEEPS = 4,
  localparam int unsigned SLOT_W = sweep_integ_pkg::index_width(SWEEPS),
  localparam int unsigned CNT_W  = $clog2(SWEEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_first,
  output logic [SLOT_W-1:0] slot,
  output logic              history_live
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              begun_q, begun_d;
  logic              advance;

  assign advance = smp_valid && smp_first;

  always_comb begin
    slot_d  = slot_q;
    count_d = count_q;
    begun_d = begun_q;
    if (advance) begin
      begun_d = 1'b1;
      if (!begun_q) begin
        slot_d  = '0;
        count_d = '0;
      end else begin
        slot_d  = (slot_q == SLOT_W'(SWEEPS - 1)) ? '0 : slot_q + 1'b1;
        count_d = (count_q == CNT_W'(SWEEPS)) ? count_q : count_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      count_q <= '0;
      begun_q <= 1'b0;
    end else if (advance) begin
      slot_q  <= slot_d;
      count_q <= count_d;
      begun_q <= begun_d;
    end
  end

  assign slot         = slot_d;
  assign history_live = (count_d == CNT_W'(SWEEPS));

  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_W'(SWEEPS - 1));

  // R4
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (begun_q && count_q < CNT_W'(SWEEPS)) |-> (SLOT_W'(count_q) == slot_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(slot_q) && $stable(count_q)));
endmodule

// File: rtl/echo_history.sv
module echo_history #(
  parameter int unsigned ECHO_W = 8,
  parameter int unsigned SWEEPS = 4,
  parameter int unsigned RANGES = 16,
  localparam int unsigned SLOT_W = sweep_integ_pkg::index_width(SWEEPS),
  localparam int unsigned RIDX_W = sweep_integ_pkg::index_width(RANGES),
  localparam int unsigned DEPTH  = SWEEPS * RANGES,
  localparam int unsigned ADDR_W = sweep_integ_pkg::index_width(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [RIDX_W-1:0] range_idx,
  input  logic [ECHO_W-1:0] wr_echo,
  input  logic              live,
  output logic [ECHO_W-1:0] old_echo
);
  logic [ECHO_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] addr;

  assign addr = ADDR_W'(slot) * ADDR_W'(RANGES) + ADDR_W'(range_idx);

  // Read of the departing echo happens before this cycle's overwrite lands.
  always_comb begin
    old_echo = live ? store[addr] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[addr] <= wr_echo;
    end
  end
endmodule

// File: rtl/cell_accum.sv
module cell_accum #(
  parameter int unsigned ECHO_W = 8,
  parameter int unsigned SWEEPS = 4,
  parameter int unsigned RANGES = 16,
  localparam int unsigned RIDX_W  = sweep_integ_pkg::index_width(RANGES),
  localparam int unsigned SUM_W   = sweep_integ_pkg::total_width(ECHO_W, SWEEPS),
  localparam int unsigned MAX_SUM = SWEEPS * ((1 << ECHO_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [RIDX_W-1:0] smp_range,
  input  logic [ECHO_W-1:0] smp_echo,
  input  logic [ECHO_W-1:0] smp_old,
  output logic              res_valid,
  output logic [RIDX_W-1:0] res_range,
  output logic [SUM_W-1:0]  res_sum
);
  logic              s1_valid;
  logic [RIDX_W-1:0] s1_range;
  logic [ECHO_W-1:0] s1_echo, s1_old;
  logic [SUM_W-1:0]  totals [RANGES];
  logic [SUM_W-1:0]  prev_sum, next_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_range <= '0;
      s1_echo  <= '0;
      s1_old   <= '0;
    end else begin
      s1_valid <= smp_valid;
      if (smp_valid) begin
        s1_range <= smp_range;
        s1_echo  <= smp_echo;
        s1_old   <= smp_old;
      end
    end
  end

  always_comb begin
    prev_sum = totals[s1_range];
    next_sum = prev_sum + SUM_W'(s1_echo) - SUM_W'(s1_old);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RANGES; i++) totals[i] <= '0;
    end else if (s1_valid) begin
      totals[s1_range] <= next_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_range <= '0;
      res_sum   <= '0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_range <= s1_range;
        res_sum   <= next_sum;
      end
    end
  end

  // R3
  sum_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (({1'b0, prev_sum} + (SUM_W+1)'(s1_echo)) >= (SUM_W+1)'(s1_old)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_sum <= SUM_W'(MAX_SUM)));
endmodule

// File: rtl/sweep_integrator.sv
module sweep_integrator #(
  parameter int unsigned ECHO_W = sweep_integ_pkg::DEF_ECHO_W,
  parameter int unsigned SWEEPS = sweep_integ_pkg::DEF_SWEEPS,
  parameter int unsigned RANGES = sweep_integ_pkg::DEF_RANGES,
  localparam int unsigned RIDX_W = sweep_integ_pkg::index_width(RANGES),
  localparam int unsigned SLOT_W = sweep_integ_pkg::index_width(SWEEPS),
  localparam int unsigned SUM_W  = sweep_integ_pkg::total_width(ECHO_W, SWEEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [RIDX_W-1:0] in_range,
  input  logic [ECHO_W-1:0] in_echo,
  output logic              out_valid,
  output logic [RIDX_W-1:0] out_range,
  output logic [SUM_W-1:0]  out_sum
);
  logic [SLOT_W-1:0] cur_slot;
  logic              live;
  logic [ECHO_W-1:0] departing;

  sweep_tracker #(.SWEEPS(SWEEPS)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (in_valid),
    .smp_first    (in_first),
    .slot         (cur_slot),
    .history_live (live)
  );

  echo_history #(.ECHO_W(ECHO_W), .SWEEPS(SWEEPS), .RANGES(RANGES)) u_history (
    .clk       (clk),
    .wr_en     (in_valid),
    .slot      (cur_slot),
    .range_idx (in_range),
    .wr_echo   (in_echo),
    .live      (live),
    .old_echo  (departing)
  );

  cell_accum #(.ECHO_W(ECHO_W), .SWEEPS(SWEEPS), .RANGES(RANGES)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (in_valid),
    .smp_range (in_range),
    .smp_echo  (in_echo),
    .smp_old   (departing),
    .res_valid (out_valid),
    .res_range (out_range),
    .res_sum   (out_sum)
  );

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R2
  range_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_range == $past(in_range, 2)));
endmodule

// File: tb/test_sweep_integrator.sv
module test_sweep_integrator;
  localparam int M = 4;
  localparam int R = 16;

  // {seed[17:10], stride[9:2], reversed[1], gaps[0]}
  localparam logic [17:0] SWEEP_TAB [10] = '{
    {8'd10,  8'd3,   1'b0, 1'b0},
    {8'd200, 8'd7,   1'b0, 1'b0},
    {8'd255, 8'd1,   1'b1, 1'b0},
    {8'd0,   8'd17,  1'b0, 1'b1},
    {8'd90,  8'd250, 1'b0, 1'b0},
    {8'd33,  8'd0,   1'b1, 1'b1},
    {8'd128, 8'd64,  1'b0, 1'b0},
    {8'd5,   8'd5,   1'b0, 1'b0},
    {8'd77,  8'd13,  1'b1, 1'b0},
    {8'd250, 8'd200, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_first;
  logic [3:0] in_range;
  logic [7:0] in_echo;
  logic       out_valid;
  logic [3:0] out_range;
  logic [9:0] out_sum;

  int n_chk = 0;
  int n_fail = 0;
  int log_m [64][R];
  int m_sweep;
  bit p0_v, p1_v;
  int p0_r, p1_r, p0_s, p1_s;
  string p0_q, p1_q;
  string cur_req;

  always #5 clk = ~clk;

  sweep_integrator #(.ECHO_W(8), .SWEEPS(M), .RANGES(R)) i_sweep_integrator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_range(in_range), .in_echo(in_echo),
    .out_valid(out_valid), .out_range(out_range), .out_sum(out_sum)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_sweep = -1;
    p0_v = 1'b0;
    p1_v = 1'b0;
  endtask

  // One cycle: check the result of the sample driven two cycles back, then drive.
  task automatic step(input bit v, input bit f, input int r, input int e);
    int exp_s;
    @(negedge clk);
    if (p1_v) begin
      chk(out_valid === 1'b1, "R2", int'(out_valid), 1);
      chk(int'(out_range) == p1_r, "R2", int'(out_range), p1_r);
      chk(int'(out_sum) == p1_s, p1_q, int'(out_sum), p1_s);
    end else begin
      chk(out_valid === 1'b0, "R9", int'(out_valid), 0);
    end
    p1_v = p0_v; p1_r = p0_r; p1_s = p0_s; p1_q = p0_q;
    in_valid = v;
    in_first = f;
    in_range = 4'(r);
    in_echo  = 8'(e);
    p0_v = v;
    if (v) begin
      if (f) m_sweep++;
      log_m[m_sweep][r] = e;
      exp_s = 0;
      for (int k = 0; k < M; k++)
        if (m_sweep - k >= 0) exp_s += log_m[m_sweep - k][r];
      p0_r = r; p0_s = exp_s; p0_q = cur_req;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_first = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_first = 1'b0;
    in_range = '0;
    in_echo = '0;
    model_clear();
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    rst_n = 1'b1;

    // Table of sweeps walked by one loop.
    for (int s = 0; s < 10; s++) begin
      automatic int seed   = int'(SWEEP_TAB[s][17:10]);
      automatic int stride = int'(SWEEP_TAB[s][9:2]);
      automatic bit rev    = SWEEP_TAB[s][1];
      automatic bit gaps   = SWEEP_TAB[s][0];
      if (rev) cur_req = "R8";
      else if (gaps) cur_req = "R6";
      else if (s < M) cur_req = "R4";
      else cur_req = "R3";
      if (gaps) step(1'b0, 1'b1, 3, 99);
      for (int k = 0; k < R; k++) begin
        automatic int r = rev ? (R - 1 - k) : k;
        if (gaps && k == 7) begin
          step(1'b0, 1'b1, 0, 0);
          step(1'b0, 1'b0, 0, 0);
        end
        step(1'b1, k == 0, r, (seed + stride * r) & 255);
      end
    end

    // R5: one cell loud, the rest silent, over a full window.
    cur_req = "R5";
    for (int s = 0; s < M + 1; s++)
      for (int k = 0; k < R; k++)
        step(1'b1, k == 0, k, (k == 5) ? 200 : 0);
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 0, 0);

    // R1 / R7: reset mid-run, then full-scale sweeps past the window depth.
    do_reset();
    for (int s = 0; s < M + 2; s++) begin
      cur_req = (s == 0) ? "R1" : "R7";
      for (int k = 0; k < R; k++)
        step(1'b1, k == 0, k, 255);
    end
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule